// File: doc/BRIEF.md
# Masked Event Trigger and Pause Qualifier

This block watches a bus of external event lines coming from the timing section and turns them into two qualifiers for a pattern sequencer: a single-cycle trigger pulse and a level-valued pause request. Three pattern/mask pairs are held in host-writable registers. The first-stage pair and the second-stage pair define the trigger. The pause pair defines the condition for a conditional pause. A mask bit set to 1 makes the corresponding event bit a don't-care.

The trigger runs in one of two modes. In concurrent mode it fires when both stage patterns match on the same sampled cycle. In sequential mode a first-stage match arms the second stage, and the trigger fires on the first later cycle in which the second-stage pattern matches. A host-loaded emulation register can replace the real event lines as the comparison source for all three comparators, so that a test program can be checked without live hardware events.

The trigger sequencer has four states. ST_IDLE is unarmed. ST_WAIT_D waits for the first-stage condition (or for both conditions in concurrent mode). ST_WAIT_T waits for the second stage in sequential mode. ST_FIRED holds after a trigger until disarm. Transitions: arm low from any state goes to ST_IDLE; ST_IDLE with arm high goes to ST_WAIT_D; ST_WAIT_D goes to ST_FIRED on a joint match in concurrent mode, or to ST_WAIT_T on a first-stage match in sequential mode; ST_WAIT_T goes to ST_FIRED on a second-stage match; ST_FIRED stays until arm falls.

Top module: `evt_trig_unit`

## Requirements
- R1: A write with wr_en high stores wr_data into the register picked by wr_addr, and the stored value takes effect from the next clock cycle. The addresses are: 0 first-stage pattern, 1 first-stage mask, 2 second-stage pattern, 3 second-stage mask, 4 pause pattern, 5 pause mask, 6 emulation value, 7 control.
- R2: An event bit matches when its mask bit is 1 or when the source bit equals the pattern bit. A pair matches only when every bit matches.
- R3: With control bit 0 at 0 (concurrent mode), an armed unit in ST_WAIT_D fires when the first-stage and second-stage pairs both match at the same clock edge.
- R4: With control bit 0 at 1 (sequential mode), a first-stage match moves ST_WAIT_D to ST_WAIT_T. The trigger fires on the first later edge with a second-stage match. A second-stage match at the same edge as the first-stage match, or before it, does not fire.
- R5: When arm is seen high in ST_IDLE, the unit enters ST_WAIT_D. Event matches at that same edge are not evaluated.
- R6: arm low returns the unit to ST_IDLE at the next edge and clears the stage-two state. trig_o stays low in the cycle after any edge where arm is low.
- R7: trig_o is registered. It is high for exactly one cycle after the qualifying edge and does not rise again until arm has gone low and then high.
- R8: pause_o is combinational and level-valued. It equals the pause-pair match against the current comparison source in every cycle.
- R9: Control bit 1 at 1 makes the emulation register the comparison source for all three pairs. At 0 the source is evt_in and the emulation register has no effect.
- R10: After reset all registers are zero, the state is ST_IDLE and trig_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | EVW | Register write data |
| evt_in | input | EVW | External event lines |
| arm | input | 1 | Arm level; low disarms |
| trig_o | output | 1 | Single-cycle trigger pulse |
| pause_o | output | 1 | Conditional pause request |

## Verification
The concurrent trigger is swept over every first-stage pattern and mask against every event value, with a second-stage pair fixed so that the two pairs disagree on some bits. The sweep shows whether both pairs are required and whether masks are applied per bit. The pause comparator is swept over every pattern, mask and input combination.

Directed sequences in sequential mode cover the following cases:
- first stage then second stage, which must fire;
- second stage before first stage, which must not fire;
- both stages in the same cycle, which must not fire at once;
- disarm during stage two;
- repeated matches after firing, which must not fire again.

Source selection is tested with the emulation register matching while the real lines do not, and the other way round.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT_D = 2'd1,
        ST_WAIT_T = 2'd2,
        ST_FIRED  = 2'd3
    } trig_state_t;

    localparam int NUM_PAIRS = 3;
    localparam int PAIR_D    = 0;
    localparam int PAIR_T    = 1;
    localparam int PAIR_P    = 2;

    localparam logic [2:0] A_D_PAT  = 3'd0;
    localparam logic [2:0] A_D_MSK  = 3'd1;
    localparam logic [2:0] A_T_PAT  = 3'd2;
    localparam logic [2:0] A_T_MSK  = 3'd3;
    localparam logic [2:0] A_P_PAT  = 3'd4;
    localparam logic [2:0] A_P_MSK  = 3'd5;
    localparam logic [2:0] A_EMU    = 3'd6;
    localparam logic [2:0] A_CTRL   = 3'd7;

    localparam int CTRL_SEQ  = 0;
    localparam int CTRL_XSRC = 1;

endpackage

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_pkg::*;
#(
    parameter int EVW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [EVW-1:0]       wr_data,
    output logic [EVW-1:0]       pat_o [NUM_PAIRS],
    output logic [EVW-1:0]       msk_o [NUM_PAIRS],
    output logic [EVW-1:0]       emu_o,
    output logic                 seq_mode_o,
    output logic                 emu_sel_o
);
    localparam int NREG = 2 * NUM_PAIRS + 1;

    logic [EVW-1:0] regs_q [NREG];
    logic [1:0]     ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) ctrl_q <= wr_data[1:0];
            else                   regs_q[wr_addr] <= wr_data;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PAIRS; g++) begin : g_pair
            assign pat_o[g] = regs_q[2*g];
            assign msk_o[g] = regs_q[2*g+1];
        end
    endgenerate

    assign emu_o      = regs_q[A_EMU];
    assign seq_mode_o = ctrl_q[CTRL_SEQ];
    assign emu_sel_o  = ctrl_q[CTRL_XSRC];

    // R1
    dmask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_D_MSK) |=> (msk_o[PAIR_D] == $past(wr_data)));

endmodule

// File: rtl/evt_match.sv
module evt_match #(
    parameter int EVW = 8
) (
    input  logic [EVW-1:0] pat_i,
    input  logic [EVW-1:0] msk_i,
    input  logic [EVW-1:0] src_i,
    output logic           hit_o
);
    logic [EVW-1:0] bit_ok;

    always_comb begin
        bit_ok = ~(src_i ^ pat_i) | msk_i;
        hit_o  = &bit_ok;
    end
endmodule

// File: rtl/evt_seq_fsm.sv
module evt_seq_fsm
    import evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic seq_i,
    input  logic d_hit_i,
    input  logic t_hit_i,
    output logic trig_o
);
    trig_state_t state_q, state_d;
    logic        fire;
    logic        trig_q;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (!arm_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_WAIT_D;
                ST_WAIT_D: begin
                    if (!seq_i) begin
                        if (d_hit_i && t_hit_i) begin
                            fire    = 1'b1;
                            state_d = ST_FIRED;
                        end
                    end else if (d_hit_i) begin
                        state_d = ST_WAIT_T;
                    end
                end
                ST_WAIT_T: begin
                    if (t_hit_i) begin
                        fire    = 1'b1;
                        state_d = ST_FIRED;
                    end
                end
                ST_FIRED:  state_d = ST_FIRED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= fire;
    end

    assign trig_o = trig_q;

    // R7
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> !trig_q);

    // R6
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !trig_q);

    // R4
    seq_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_i && state_q == ST_WAIT_D) |=> !trig_q);

    // R5
    idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !trig_q);

endmodule

// File: rtl/evt_trig_unit.sv
module evt_trig_unit
    import evt_pkg::*;
#(
    parameter int EVW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [EVW-1:0] wr_data,
    input  logic [EVW-1:0] evt_in,
    input  logic           arm,
    output logic           trig_o,
    output logic           pause_o
);
    logic [EVW-1:0] pat [NUM_PAIRS];
    logic [EVW-1:0] msk [NUM_PAIRS];
    logic [EVW-1:0] emu;
    logic           seq_mode;
    logic           emu_sel;
    logic [EVW-1:0] src;
    logic [NUM_PAIRS-1:0] hit;

    evt_regfile #(.EVW(EVW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pat_o      (pat),
        .msk_o      (msk),
        .emu_o      (emu),
        .seq_mode_o (seq_mode),
        .emu_sel_o  (emu_sel)
    );

    assign src = emu_sel ? emu : evt_in;

    genvar g;
    generate
        for (g = 0; g < NUM_PAIRS; g++) begin : g_cmp
            evt_match #(.EVW(EVW)) u_cmp (
                .pat_i (pat[g]),
                .msk_i (msk[g]),
                .src_i (src),
                .hit_o (hit[g])
            );
        end
    endgenerate

    evt_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (arm),
        .seq_i   (seq_mode),
        .d_hit_i (hit[PAIR_D]),
        .t_hit_i (hit[PAIR_T]),
        .trig_o  (trig_o)
    );

    assign pause_o = hit[PAIR_P];

    // R2
    full_mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msk[PAIR_P] == '1) |-> pause_o);

    // R9
    emu_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_sel && msk[PAIR_P] == '0 && emu == pat[PAIR_P]) |-> pause_o);

endmodule

// File: tb/sim_evt_trig_unit.sv
module sim_evt_trig_unit;
    localparam int W = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, wr_en, arm;
    logic [2:0]   wr_addr;
    logic [W-1:0] wr_data, evt_in;
    logic         trig, pause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    evt_trig_unit #(.EVW(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_in(evt_in), .arm(arm),
        .trig_o(trig), .pause_o(pause)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick;
        wr_en = 1'b0;
    endtask

    task automatic rearm;
        arm = 1'b0; tick;
        arm = 1'b1; tick;
    endtask

    function automatic logic hit(input logic [W-1:0] p, input logic [W-1:0] m,
                                 input logic [W-1:0] s);
        return ((s ^ p) & ~m) == '0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        evt_in = '0; arm = 1'b0;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // R10 reset state: zero registers mean pause pattern 0, mask 0
        chk(trig, 1'b0, "R10 trig after reset");
        chk(pause, 1'b1, "R10 pause with zero regs, evt 0");
        evt_in = 4'h1; #1;
        chk(pause, 1'b0, "R10 pause with zero regs, evt 1");

        // R1 R2 R3 concurrent sweep
        wr(3'd7, 4'h0);
        for (int d = 0; d < 16; d++) begin
            for (int dm = 0; dm < 16; dm++) begin
                wr(3'd0, d[W-1:0]);
                wr(3'd1, dm[W-1:0]);
                wr(3'd2, d[W-1:0] ^ 4'h3);
                wr(3'd3, 4'h8);
                for (int e = 0; e < 16; e++) begin
                    rearm;
                    evt_in = e[W-1:0];
                    tick;
                    chk(trig, hit(d[W-1:0], dm[W-1:0], e[W-1:0]) &&
                              hit(d[W-1:0] ^ 4'h3, 4'h8, e[W-1:0]),
                        "R1 R2 R3 concurrent sweep");
                end
            end
        end

        // R8 pause sweep
        for (int p = 0; p < 16; p++) begin
            for (int pm = 0; pm < 16; pm++) begin
                wr(3'd4, p[W-1:0]);
                wr(3'd5, pm[W-1:0]);
                for (int e = 0; e < 16; e++) begin
                    evt_in = e[W-1:0]; #1;
                    chk(pause, hit(p[W-1:0], pm[W-1:0], e[W-1:0]), "R8 pause sweep");
                end
            end
        end

        // R5 arming edge ignores matches
        wr(3'd0, 4'hA); wr(3'd1, 4'h0); wr(3'd2, 4'hA); wr(3'd3, 4'h0);
        arm = 1'b0; tick;
        evt_in = 4'hA; arm = 1'b1; tick;
        chk(trig, 1'b0, "R5 match at arming edge ignored");
        tick;
        chk(trig, 1'b1, "R5 match after arming fires");

        // R6 no trigger while arm low
        arm = 1'b0; tick; tick;
        chk(trig, 1'b0, "R6 arm low keeps trig low");

        // R4 R7 sequential mode
        wr(3'd7, 4'h1);
        wr(3'd2, 4'h5);
        rearm;
        evt_in = 4'hA; tick;
        chk(trig, 1'b0, "R4 first stage alone");
        evt_in = 4'h0; tick; tick;
        chk(trig, 1'b0, "R4 waiting for second stage");
        evt_in = 4'h5; tick;
        chk(trig, 1'b1, "R4 second stage after first");
        tick;
        chk(trig, 1'b0, "R7 single-cycle pulse");
        evt_in = 4'hA; tick;
        evt_in = 4'h5; tick;
        chk(trig, 1'b0, "R7 no refire without rearm");

        rearm;
        evt_in = 4'h5; tick;
        chk(trig, 1'b0, "R4 second stage before first");
        evt_in = 4'hA; tick;
        chk(trig, 1'b0, "R4 first stage after second");
        evt_in = 4'h5; tick;
        chk(trig, 1'b1, "R4 ordered second stage fires");

        wr(3'd2, 4'hA);
        rearm;
        evt_in = 4'hA; tick;
        chk(trig, 1'b0, "R4 same-cycle match does not fire");
        tick;
        chk(trig, 1'b1, "R4 later cycle fires");

        wr(3'd2, 4'h5);
        rearm;
        evt_in = 4'hA; tick;
        evt_in = 4'h0; arm = 1'b0; tick;
        arm = 1'b1; tick;
        evt_in = 4'h5; tick;
        chk(trig, 1'b0, "R6 disarm clears stage two");

        // R9 source selection
        wr(3'd7, 4'h2);
        wr(3'd2, 4'hA);
        wr(3'd4, 4'hA); wr(3'd5, 4'h0);
        wr(3'd6, 4'hA);
        evt_in = 4'h5;
        rearm;
        tick;
        chk(trig, 1'b1, "R9 emulation source fires");
        chk(pause, 1'b1, "R9 emulation source pause");
        wr(3'd7, 4'h0);
        rearm;
        tick;
        chk(trig, 1'b0, "R9 emulation ignored on real source");
        chk(pause, 1'b0, "R9 pause follows real lines");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule